// File: doc/BRIEF.md
# Processor tick timer

A per-core timer made of a free-running 32-bit count register and a control register. The count register advances by one on every clock edge while the timer runs. The control register holds four things: a 28-bit match period, a 2-bit run mode, an interrupt-enable bit and an interrupt-pending bit. A match occurs when the low 28 bits of the count equal the period. On a match the run mode decides what the counter does next, and the pending bit is set. The interrupt output is a level signal that is high while pending and enable are both set.

Software reaches the block through a plain special-register port: an address, a write strobe, write data and combinational read data. The port decodes three addresses. Address 0 selects the control register and address 1 the count register. Address 2 selects a read-only capability register whose bit 0 reports that the timer is present. Every other address reads zero. An operating system normally runs the timer in continuous mode as a clock source. To arm a one-shot event it writes a future count into the period field with the enable bit set. To acknowledge the event it writes the control register with only the mode bits set.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register and the count register both read 0, and `tick_irq` is low.
- R2: Control bits 31:30 select the run mode. Mode 00 halts the counter at its current value and never produces a match.
- R3: In mode 11 (continuous) the counter adds one on every edge. It passes a match without change and wraps from 0xFFFFFFFF to 0.
- R4: A match is the low 28 bits of the count (bits 27:0) equal to the period field (control bits 27:0), in any mode other than 00. Count bits 31:28 play no part. A match sets the pending bit (control bit 28) on the following edge, whatever the state of the enable bit.
- R5: `tick_irq` is high exactly when both the pending bit (bit 28) and the enable bit (bit 29) of the control register are set.
- R6: In mode 01 (restart) the counter becomes 0 on the edge that follows a cycle in which a match is present.
- R7: In mode 10 (stop) the counter holds the matching value for as long as the mode stays 10.
- R8: A write to address 0 replaces the whole control register, the pending bit included. This write takes priority over a match in the same cycle. Writing 0xC0000000 therefore clears pending, lowers `tick_irq` and leaves the counter running.
- R9: A write to address 1 loads the full 32-bit write data into the counter. This write takes priority over counting, restart and stop.
- R10: Address 2 reads 0x00000001. A write to address 2 changes neither the capability value nor either timer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The counter advances on each rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 capability |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| tick_irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The in-module assertions check the following on every cycle:
- the counter step in each run mode (hold, increment with wrap, return to zero, freeze)
- that a match sets the pending bit
- that a preload lands exactly
- that an acknowledge lowers the interrupt

The bench runs a behavioural reference model in parallel with the design and compares the interrupt and the addressed register every cycle. Its scenarios show what the per-cycle properties cannot:
- that the compare ignores count bits 31:28
- that a control write beats a match in the same cycle
- that a write to the capability address disturbs nothing
- the exact cycle at which the interrupt rises after the count is armed

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W    = 32,
  parameter int PER_W    = 28,
  parameter int ADDR_W   = 2,
  parameter int ADDR_CTL = 0,
  parameter int ADDR_CNT = 1,
  parameter int ADDR_CAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              tick_irq
);

  localparam int IP_BIT  = PER_W;
  localparam int IE_BIT  = PER_W + 1;
  localparam int MODE_LO = PER_W + 2;
  localparam int MODE_HI = PER_W + 3;

  typedef enum logic [1:0] {
    M_OFF     = 2'b00,
    M_RESTART = 2'b01,
    M_STOP    = 2'b10,
    M_CONT    = 2'b11
  } mode_e;

  logic [CNT_W-1:0] cnt, cnt_nx, ctl;
  mode_e            mode;
  logic             hit, ctl_we, cnt_we;

  assign mode   = mode_e'(ctl[MODE_HI:MODE_LO]);
  assign ctl_we = reg_we && (reg_addr == ADDR_W'(ADDR_CTL));
  assign cnt_we = reg_we && (reg_addr == ADDR_W'(ADDR_CNT));
  assign hit    = (mode != M_OFF) && (cnt[PER_W-1:0] == ctl[PER_W-1:0]);

  always_comb begin
    cnt_nx = cnt;
    case (mode)
      M_OFF:     cnt_nx = cnt;
      M_RESTART: cnt_nx = hit ? '0 : cnt + 1'b1;
      M_STOP:    cnt_nx = hit ? cnt : cnt + 1'b1;
      M_CONT:    cnt_nx = cnt + 1'b1;
    endcase
    if (cnt_we) cnt_nx = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (ctl_we) ctl <= reg_wdata;
    else if (hit)    ctl[IP_BIT] <= 1'b1;

  assign tick_irq = ctl[IP_BIT] & ctl[IE_BIT];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTL))      reg_rdata = ctl;
    else if (reg_addr == ADDR_W'(ADDR_CNT)) reg_rdata = cnt;
    else if (reg_addr == ADDR_W'(ADDR_CAP)) reg_rdata = CNT_W'(1);
  end

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !cnt_we) |=> $stable(cnt)); // R2
  AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CONT && !cnt_we) |=> cnt == $past(cnt) + 1'b1); // R3
  AST_MATCH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctl_we) |=> ctl[IP_BIT]); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RESTART && hit && !cnt_we) |=> cnt == '0); // R6
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP && hit && !cnt_we) |=> $stable(cnt)); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !reg_wdata[IP_BIT]) |=> !tick_irq); // R8
  AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt == $past(reg_wdata)); // R9

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt = '0;
  logic [31:0] m_ctl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_irq(tick_irq)
  );

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctl;
      2'd1:    return m_cnt;
      2'd2:    return 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [1:0] md;
    logic match;
    logic [31:0] nc, nt;
    if (!rst_n) begin
      m_cnt = '0;
      m_ctl = '0;
    end else begin
      md    = m_ctl[31:30];
      match = (md != 2'b00) && (m_cnt[27:0] == m_ctl[27:0]);
      nc    = m_cnt;
      nt    = m_ctl;
      if (md == 2'b11) nc = m_cnt + 1;
      else if (md == 2'b01) nc = match ? 32'd0 : m_cnt + 1;
      else if (md == 2'b10) nc = match ? m_cnt : m_cnt + 1;
      if (match) nt[28] = 1'b1;
      if (reg_we && reg_addr == 2'd1) nc = reg_wdata;
      if (reg_we && reg_addr == 2'd0) nt = reg_wdata;
      m_cnt = nc;
      m_ctl = nt;
    end
    #3;
    check("R5 model irq", {31'd0, tick_irq}, {31'd0, m_ctl[28] & m_ctl[29]});
    check("R3 model read", reg_rdata, m_read(reg_addr));
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    check(tag, {31'd0, tick_irq}, {31'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    chk("R1 ctl", 2'd0, 32'h0);
    chk("R1 cnt", 2'd1, 32'h0);
    chk_irq("R1 irq", 1'b0);

    wr(2'd1, 32'd5); idle(3);
    chk("R2 halted", 2'd1, 32'd5);

    chk("R10 cap", 2'd2, 32'd1);
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R10 cap after write", 2'd2, 32'd1);
    chk("R10 ctl untouched", 2'd0, 32'h0);
    chk("R10 cnt untouched", 2'd1, 32'd5);

    wr(2'd1, 32'd0);
    wr(2'd0, 32'hC000_000A);
    idle(5);
    chk("R3 count", 2'd1, 32'd5);
    idle(15);
    chk("R3 past match", 2'd1, 32'd20);
    chk("R4 pending without enable", 2'd0, 32'hD000_000A);
    chk_irq("R5 no irq without enable", 1'b0);

    wr(2'd0, 32'hE000_001E);
    idle(8);
    chk_irq("R5 irq before match", 1'b0);
    idle(2);
    chk_irq("R5 irq on match", 1'b1);
    wr(2'd0, 32'hC000_0000);
    chk_irq("R8 ack", 1'b0);
    chk("R8 counter runs", 2'd1, 32'd32);

    wr(2'd1, 32'hF000_0000);
    wr(2'd0, 32'hC000_0003);
    idle(2);
    chk("R4 not yet", 2'd0, 32'hC000_0003);
    idle(1);
    chk("R4 low bits match", 2'd0, 32'hD000_0003);

    wr(2'd1, 32'hFFFF_FFFE);
    idle(3);
    chk("R3 wrap", 2'd1, 32'd1);

    wr(2'd1, 32'd0);
    wr(2'd0, 32'h4000_0004);
    idle(3);
    chk("R6 at match", 2'd1, 32'd4);
    idle(1);
    chk("R6 restart", 2'd1, 32'd0);
    idle(1);
    chk("R6 counts again", 2'd1, 32'd1);

    wr(2'd1, 32'd0);
    wr(2'd0, 32'h8000_0006);
    idle(5);
    chk("R7 at match", 2'd1, 32'd6);
    idle(4);
    chk("R7 frozen", 2'd1, 32'd6);
    wr(2'd0, 32'hC000_0006);
    chk("R8 write beats match", 2'd0, 32'hC000_0006);
    idle(2);
    chk("R7 resumes", 2'd1, 32'd8);

    wr(2'd1, 32'd0);
    wr(2'd0, 32'h4000_0002);
    idle(1);
    wr(2'd1, 32'h77);
    chk("R9 preload beats restart", 2'd1, 32'h77);

    wr(2'd0, 32'h0);
    idle(3);
    chk("R2 off holds", 2'd1, 32'h78);

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule